// File: doc/BRIEF.md
# Write-Synchronized Peripheral Control Register

This block is the control register of a peripheral whose core logic runs on a clock that is separate from, and unrelated to, the bus clock. It holds three fields: a clock-select bit, an enable bit and a self-clearing software-reset trigger. The clock-select field goes straight to the clock multiplexer outside the block. Writes to the enable and reset fields are carried into the core clock domain by toggle handshakes. The whole time a transfer is in flight, a per-field busy flag is set in a separate status register.

Software writes the control word and polls the status word until the relevant busy flag drops. At that point the core has taken the new value. If a write to the control word arrives while any transfer is still pending, the bus is held with a wait signal, so no update is lost. A reset request overrides every other field written with it. Once it completes, the core is disabled and all fields are back at zero.

Top module: `sync_ctrl_reg`

## Requirements
- R1: After reset the control word (address 0) and the status word (address 1) both read 0x00, `clk_sel` is 0 and `core_enable` is 0.
- R2: In an accepted control write with bit 0 clear, the enable field (bit 1) and the clock-select field (bit 4) read back with the written values from the first bus cycle after the write.
- R3: An accepted control write with bit 0 clear sets the enable busy flag (status bit 1) in the same cycle as the readback. The flag later clears, and `core_enable` then equals the written bit 1.
- R4: `clk_sel` follows the written bit 4 from the first bus cycle after the write, with no handshake delay.
- R5: Writing 0 to control bit 0 starts no reset: status bit 0 stays 0 and control bit 0 reads 0.
- R6: Writing 1 to control bit 0 makes control bit 0 and status bit 0 both read 1 until the reset completes in the core domain. In every cycle the two bits read equal, so they clear together.
- R7: In a write with control bit 0 set, the enable and clock-select values in that same write are discarded. Until the reset completes, the previous field values still read back and `clk_sel` is unchanged.
- R8: When a reset completes, the control word reads 0x00, `clk_sel` is 0 and `core_enable` is 0, whatever state came before.
- R9: A control write that arrives while a busy flag is set is stalled by `wr_wait`. The write is taken once the flags clear, and its value is then applied.
- R10: Control bits 7:5, 3 and 2 read as 0 whatever was written. Status bits 7:2 read 0. Addresses 2 and 3 read 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock |
| bus_rst_n | input | 1 | Active-low asynchronous reset, bus domain |
| core_clk | input | 1 | Peripheral core clock |
| core_rst_n | input | 1 | Active-low asynchronous reset, core domain |
| wr_en | input | 1 | Write strobe, held until the write is accepted |
| wr_addr | input | 2 | Write address (0 control, 1 status) |
| wr_data | input | 8 | Write data |
| wr_wait | output | 1 | Write stalled; keep the strobe and data stable |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data, combinational from `rd_addr` |
| clk_sel | output | 1 | Core clock select: 0 general clock, 1 low-power 32.768 kHz clock |
| core_enable | output | 1 | Enable as applied in the core clock domain |

## Verification
The bench writes every one of the 256 control-word values in turn, with the core clock unrelated to the bus clock.

- Enable-type writes check that the readback is immediate while `core_enable` lags. A design that waited for the handshake before updating the readback, or that dropped busy too early, would show a stale readback or a `core_enable` that disagrees once busy is clear.
- Reset-type writes check that the other fields are ignored. A design that let them through would change `clk_sel` or the readback right away. These writes also compare control bit 0 with status bit 0 on every cycle, so a design that cleared one of them a cycle early is caught.
- Back-to-back enable writes check that the second write stalls rather than being lost. Writes to the unused bits and addresses check that nothing leaks into the reserved positions.

// File: rtl/scr_pkg.sv
package scr_pkg;
   // handshake channel indices
   localparam int NCH    = 2;
   localparam int CH_RST = 0;
   localparam int CH_EN  = 1;
endpackage

// File: rtl/scr_sync.sv
module scr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("scr_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/scr_tgl_src.sv
// Bus-side half of a toggle handshake: flips the request on launch,
// brings the acknowledge toggle back and reports a pending transfer.
module scr_tgl_src #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic launch,
   input  logic ack_async,
   output logic req_tgl,
   output logic busy
);
   logic req_q;
   logic ack_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      req_q <= 1'b0;
      else if (launch) req_q <= ~req_q;
   end

   scr_sync #(.STAGES(STAGES)) u_ack_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ack_async),
      .q     (ack_s)
   );

   assign req_tgl = req_q;
   assign busy    = req_q ^ ack_s;
endmodule

// File: rtl/scr_tgl_dst.sv
// Core-side half of a toggle handshake: one-cycle pulse per request,
// acknowledge toggle returned in the same cycle the pulse acts.
module scr_tgl_dst #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_async,
   output logic ack_tgl,
   output logic pulse
);
   logic req_s;
   logic ack_q;

   scr_sync #(.STAGES(STAGES)) u_req_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (req_async),
      .q     (req_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ack_q <= 1'b0;
      else        ack_q <= req_s;
   end

   assign pulse   = req_s ^ ack_q;
   assign ack_tgl = ack_q;
endmodule

// File: rtl/scr_bus_regs.sv
module scr_bus_regs #(
   parameter int DATA_W     = 8,
   parameter int ADDR_W     = 2,
   parameter int CTRL_ADDR  = 0,
   parameter int STAT_ADDR  = 1,
   parameter int CLKSEL_BIT = 4,
   parameter int EN_BIT     = 1,
   parameter int RST_BIT    = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              en_busy,
   input  logic              rst_busy,
   output logic              wr_wait,
   output logic [DATA_W-1:0] rd_data,
   output logic              en_launch,
   output logic              rst_launch,
   output logic              enable_q,
   output logic              clk_sel
);
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

   logic ctrl_hit;
   logic accept;
   logic pend_q;
   logic cs_q;
   logic en_q;

   assign ctrl_hit   = wr_en && (wr_addr == CTRL_A);
   // any outstanding transfer or reset wrap-up stalls a control write
   assign wr_wait    = ctrl_hit && (en_busy || rst_busy || pend_q);
   assign accept     = ctrl_hit && !wr_wait;
   assign rst_launch = accept && wr_data[RST_BIT];
   assign en_launch  = accept && !wr_data[RST_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         cs_q   <= 1'b0;
         pend_q <= 1'b0;
      end else if (pend_q && !rst_busy) begin
         en_q   <= 1'b0;
         cs_q   <= 1'b0;
         pend_q <= 1'b0;
      end else if (rst_launch) begin
         pend_q <= 1'b1;
      end else if (en_launch) begin
         en_q <= wr_data[EN_BIT];
         cs_q <= wr_data[CLKSEL_BIT];
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == CTRL_A) begin
         rd_data[CLKSEL_BIT] = cs_q;
         rd_data[EN_BIT]     = en_q;
         rd_data[RST_BIT]    = rst_busy;
      end else if (rd_addr == STAT_A) begin
         rd_data[EN_BIT]  = en_busy;
         rd_data[RST_BIT] = rst_busy;
      end
   end

   assign enable_q = en_q;
   assign clk_sel  = cs_q;
endmodule

// File: rtl/scr_core_ctl.sv
module scr_core_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic en_pulse,
   input  logic rst_pulse,
   input  logic en_value,
   output logic core_enable
);
   logic en_q;

   // en_value is held stable by the bus side while its transfer is pending
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         en_q <= 1'b0;
      else if (rst_pulse) en_q <= 1'b0;
      else if (en_pulse)  en_q <= en_value;
   end

   assign core_enable = en_q;
endmodule

// File: rtl/sync_ctrl_reg.sv
module sync_ctrl_reg #(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 2,
   parameter int SYNC_STAGES = 2,
   parameter int CTRL_ADDR   = 0,
   parameter int STAT_ADDR   = 1,
   parameter int CLKSEL_BIT  = 4,
   parameter int EN_BIT      = 1,
   parameter int RST_BIT     = 0
) (
   input  logic              bus_clk,
   input  logic              bus_rst_n,
   input  logic              core_clk,
   input  logic              core_rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_wait,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              clk_sel,
   output logic              core_enable
);
   import scr_pkg::*;

   generate
      if (CLKSEL_BIT >= DATA_W || EN_BIT >= DATA_W || RST_BIT >= DATA_W) begin : g_bad_pos
         $error("field position outside the data word");
      end
      if (CLKSEL_BIT == EN_BIT || CLKSEL_BIT == RST_BIT || EN_BIT == RST_BIT) begin : g_bad_overlap
         $error("field positions must be distinct");
      end
      if (CTRL_ADDR == STAT_ADDR || CTRL_ADDR >= (1 << ADDR_W) || STAT_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("register addresses invalid");
      end
   endgenerate

   logic [NCH-1:0] launch;
   logic [NCH-1:0] busy;
   logic [NCH-1:0] req_tgl;
   logic [NCH-1:0] ack_tgl;
   logic [NCH-1:0] pulse;
   logic           enable_q;

   scr_bus_regs #(
      .DATA_W     (DATA_W),
      .ADDR_W     (ADDR_W),
      .CTRL_ADDR  (CTRL_ADDR),
      .STAT_ADDR  (STAT_ADDR),
      .CLKSEL_BIT (CLKSEL_BIT),
      .EN_BIT     (EN_BIT),
      .RST_BIT    (RST_BIT)
   ) u_regs (
      .clk        (bus_clk),
      .rst_n      (bus_rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .rd_addr    (rd_addr),
      .en_busy    (busy[CH_EN]),
      .rst_busy   (busy[CH_RST]),
      .wr_wait    (wr_wait),
      .rd_data    (rd_data),
      .en_launch  (launch[CH_EN]),
      .rst_launch (launch[CH_RST]),
      .enable_q   (enable_q),
      .clk_sel    (clk_sel)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_chan
      scr_tgl_src #(.STAGES(SYNC_STAGES)) u_src (
         .clk       (bus_clk),
         .rst_n     (bus_rst_n),
         .launch    (launch[c]),
         .ack_async (ack_tgl[c]),
         .req_tgl   (req_tgl[c]),
         .busy      (busy[c])
      );
      scr_tgl_dst #(.STAGES(SYNC_STAGES)) u_dst (
         .clk       (core_clk),
         .rst_n     (core_rst_n),
         .req_async (req_tgl[c]),
         .ack_tgl   (ack_tgl[c]),
         .pulse     (pulse[c])
      );
   end

   scr_core_ctl u_core (
      .clk         (core_clk),
      .rst_n       (core_rst_n),
      .en_pulse    (pulse[CH_EN]),
      .rst_pulse   (pulse[CH_RST]),
      .en_value    (enable_q),
      .core_enable (core_enable)
   );
endmodule

// File: rtl/scr_ctrl_chk.sv
module scr_ctrl_chk #(
   parameter int DATA_W     = 8,
   parameter int ADDR_W     = 2,
   parameter int CTRL_ADDR  = 0,
   parameter int CLKSEL_BIT = 4,
   parameter int EN_BIT     = 1,
   parameter int RST_BIT    = 0
) (
   input logic              bus_clk,
   input logic              bus_rst_n,
   input logic              core_clk,
   input logic              core_rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              wr_wait,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [DATA_W-1:0] rd_data,
   input logic              clk_sel,
   input logic              core_enable,
   input logic              enable_q,
   input logic              en_busy,
   input logic              rst_busy,
   input logic              rst_pulse
);
   localparam logic [ADDR_W-1:0] CA = ADDR_W'(CTRL_ADDR);
   localparam logic [DATA_W-1:0] LIVE =
      (DATA_W'(1) << CLKSEL_BIT) | (DATA_W'(1) << EN_BIT) | (DATA_W'(1) << RST_BIT);

   logic take;
   assign take = wr_en && (wr_addr == CA) && !wr_wait;

   p_readback_r2: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (take && !wr_data[RST_BIT]) |=> (enable_q == $past(wr_data[EN_BIT])));

   p_busy_set_r3: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (take && !wr_data[RST_BIT]) |=> en_busy);

   p_clksel_direct_r4: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (take && !wr_data[RST_BIT]) |=> (clk_sel == $past(wr_data[CLKSEL_BIT])));

   p_rst_flag_r6: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (rd_addr == CA) |-> (rd_data[RST_BIT] == rst_busy));

   p_precedence_r7: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (take && wr_data[RST_BIT]) |=> ($stable(clk_sel) && $stable(enable_q) && rst_busy));

   p_core_off_r8: assert property (@(posedge core_clk) disable iff (!core_rst_n)
      rst_pulse |=> !core_enable);

   p_stall_r9: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (wr_en && (wr_addr == CA) && (en_busy || rst_busy)) |-> wr_wait);

   p_reserved_r10: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (rd_addr == CA) |-> ((rd_data & ~LIVE) == '0));
endmodule

bind sync_ctrl_reg scr_ctrl_chk #(
   .DATA_W     (DATA_W),
   .ADDR_W     (ADDR_W),
   .CTRL_ADDR  (CTRL_ADDR),
   .CLKSEL_BIT (CLKSEL_BIT),
   .EN_BIT     (EN_BIT),
   .RST_BIT    (RST_BIT)
) u_chk (
   .bus_clk     (bus_clk),
   .bus_rst_n   (bus_rst_n),
   .core_clk    (core_clk),
   .core_rst_n  (core_rst_n),
   .wr_en       (wr_en),
   .wr_addr     (wr_addr),
   .wr_data     (wr_data),
   .wr_wait     (wr_wait),
   .rd_addr     (rd_addr),
   .rd_data     (rd_data),
   .clk_sel     (clk_sel),
   .core_enable (core_enable),
   .enable_q    (enable_q),
   .en_busy     (busy[scr_pkg::CH_EN]),
   .rst_busy    (busy[scr_pkg::CH_RST]),
   .rst_pulse   (pulse[scr_pkg::CH_RST])
);

// File: tb/sync_ctrl_reg_tb.sv
`timescale 1ns/1ps
module sync_ctrl_reg_tb_top;
   logic       bus_clk = 1'b0;
   logic       core_clk = 1'b0;
   logic       bus_rst_n = 1'b0;
   logic       core_rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [1:0] rd_addr = '0;
   logic       wr_wait;
   logic [7:0] rd_data;
   logic       clk_sel;
   logic       core_enable;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   always #5    bus_clk  = ~bus_clk;
   always #13.7 core_clk = ~core_clk;

   sync_ctrl_reg dut_i (
      .bus_clk     (bus_clk),
      .bus_rst_n   (bus_rst_n),
      .core_clk    (core_clk),
      .core_rst_n  (core_rst_n),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .wr_wait     (wr_wait),
      .rd_addr     (rd_addr),
      .rd_data     (rd_data),
      .clk_sel     (clk_sel),
      .core_enable (core_enable)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   // returns on the negedge after the accepting edge, strobe dropped
   task automatic wr(input logic [1:0] a, input logic [7:0] d, output int stalls);
      logic w;
      @(negedge bus_clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d; stalls = 0;
      while (1) begin
         #1;
         w = wr_wait;
         @(posedge bus_clk);
         if (!w) break;
         stalls++;
         @(negedge bus_clk);
      end
      @(negedge bus_clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_idle(input string req);
      logic [7:0] s;
      for (int i = 0; i < 400; i++) begin
         rd(2'd1, s);
         if (s[1:0] == 2'b00) begin
            @(negedge bus_clk);
            @(negedge bus_clk);
            return;
         end
         @(negedge bus_clk);
      end
      chk(1'b0, req, int'(s), 0);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual 0x1 expected 0x0");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] r;
      logic [7:0] s;
      logic [7:0] d;
      logic       prev_en;
      logic       prev_cs;
      bit         same;
      int         st;

      #95;
      bus_rst_n  = 1'b1;
      core_rst_n = 1'b1;
      @(negedge bus_clk);

      // R1 reset state
      rd(2'd0, r); chk(r == 8'h00, "R1 control", int'(r), 0);
      rd(2'd1, s); chk(s == 8'h00, "R1 status", int'(s), 0);
      chk(clk_sel == 1'b0, "R1 clk_sel", int'(clk_sel), 0);
      chk(core_enable == 1'b0, "R1 core_enable", int'(core_enable), 0);

      prev_en = 1'b0;
      prev_cs = 1'b0;
      for (int v = 0; v < 256; v++) begin
         d = v[7:0];
         wr(2'd0, d, st);
         if (!d[0]) begin
            rd(2'd0, r);
            chk(r == (d & 8'h12), "R2 R10 readback", int'(r), int'(d & 8'h12));
            rd(2'd1, s);
            chk(s == 8'h02, "R3 R5 busy after write", int'(s), 2);
            chk(clk_sel == d[4], "R4 clk_sel direct", int'(clk_sel), int'(d[4]));
            wait_idle("R3 busy never cleared");
            chk(core_enable == d[1], "R3 core applied", int'(core_enable), int'(d[1]));
            prev_en = d[1];
            prev_cs = d[4];
         end else begin
            rd(2'd0, r);
            rd(2'd1, s);
            chk(r[0] && s[0] && !s[1], "R6 reset pending",
                int'({r[0], s[0], s[1]}), 6);
            chk(r == {3'b000, prev_cs, 2'b00, prev_en, 1'b1}, "R7 fields discarded",
                int'(r), int'({3'b000, prev_cs, 2'b00, prev_en, 1'b1}));
            chk(clk_sel == prev_cs, "R7 clk_sel kept", int'(clk_sel), int'(prev_cs));
            same = 1'b1;
            for (int i = 0; i < 400; i++) begin
               rd(2'd0, r);
               rd(2'd1, s);
               if (r[0] != s[0]) same = 1'b0;
               if (!s[0]) break;
               @(negedge bus_clk);
            end
            chk(same, "R6 flags clear together", int'(same), 1);
            chk(s[0] == 1'b0, "R6 reset completes", int'(s[0]), 0);
            @(negedge bus_clk);
            @(negedge bus_clk);
            rd(2'd0, r);
            chk(r == 8'h00, "R8 control cleared", int'(r), 0);
            chk(clk_sel == 1'b0, "R8 clk_sel cleared", int'(clk_sel), 0);
            chk(core_enable == 1'b0, "R8 core disabled", int'(core_enable), 0);
            prev_en = 1'b0;
            prev_cs = 1'b0;
         end
      end

      // R9 back-to-back enable writes
      wr(2'd0, 8'h12, st);
      chk(st == 0, "R9 first write not stalled", st, 0);
      wr(2'd0, 8'h00, st);
      chk(st > 0, "R9 second write stalled", st, 1);
      rd(2'd0, r);
      chk(r == 8'h00, "R9 stalled value applied", int'(r), 0);
      wait_idle("R9 busy never cleared");
      chk(core_enable == 1'b0, "R9 core final", int'(core_enable), 0);

      // R10 unused addresses
      wr(2'd0, 8'h12, st);
      wait_idle("R10 busy never cleared");
      wr(2'd2, 8'hFF, st);
      wr(2'd3, 8'h00, st);
      rd(2'd2, r); chk(r == 8'h00, "R10 addr 2 reads zero", int'(r), 0);
      rd(2'd3, r); chk(r == 8'h00, "R10 addr 3 reads zero", int'(r), 0);
      rd(2'd0, r); chk(r == 8'h12, "R10 control untouched", int'(r), 8'h12);
      rd(2'd1, s); chk(s == 8'h00, "R10 status idle", int'(s), 0);
      chk(core_enable == 1'b1, "R10 core untouched", int'(core_enable), 1);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule